// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block serves a translation miss in a virtualized system. A guest virtual address must be mapped through the guest's own radix page table to a guest physical address, and every guest physical address must then be mapped through a second, host-owned table to a machine address. Guest table pointers are themselves guest physical addresses. Before the walker reads any guest table, it runs a full nested walk on that table's pointer, starting with the guest root. When the guest leaf is found, one last nested walk maps the guest physical data address.

A requester presents the guest virtual address, the guest root pointer and the nested root pointer, together with two mode bits. One mode bit turns on 2 MB leaves on the guest side and the other turns them on on the nested side. The walker then issues 64-bit reads one at a time on a memory port. It returns the machine address, a fault indication that tells guest faults from nested faults, and the number of memory reads the walk used. With n guest levels and m nested levels, a complete walk costs (n+1)(m+1)-1 reads.

Top module: `twod_walker`

## Requirements
- R1: `req_ready` is high only when idle. A request is taken in a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from the cycle after acceptance until the response, and `rsp_valid` is a single-cycle pulse.
- R2: At most one memory read is outstanding: after `mem_req`, no new `mem_req` appears until `mem_rsp_valid` has returned. Every `mem_addr` has bits 2:0 at zero, because entries are 8 bytes wide.
- R3: The first read of a walk belongs to the nested walk of the guest root. Its address is the nested root with bits 11:0 cleared, OR the guest-root bits 47:39 shifted left by 3. In general, the level index fields of an address are bits 47:39, 38:30, 29:21 and 20:12, from the top level down.
- R4: With 4 KB pages on both sides, a complete walk makes 24 reads. The machine address is the final nested leaf's bits 51:12 concatenated with the guest physical bits 11:0. The guest physical data address is the guest leaf's bits 51:12 concatenated with the virtual address bits 11:0.
- R5: With nested 2 MB leaves enabled, the nested walk ends at its third read (index bits 29:21). The final leaf gives bits 51:21 and the input address gives bits 20:0. A complete walk makes 19 reads.
- R6: With 2 MB leaves enabled on both sides, a complete walk makes 15 reads.
- R7: With only guest 2 MB leaves enabled, the guest walk has 3 levels, the offset taken from the virtual address is bits 20:0, and a complete walk makes 19 reads.
- R8: An entry with bit 0 (present) clear that was read by the guest walk ends the walk. The response then has `rsp_fault`=1, `rsp_fault_nested`=0, `rsp_maddr`=0, and `rsp_refs` equal to the reads issued, the faulting read included.
- R9: An entry with bit 0 clear that was read by any nested walk ends the walk. The response then has `rsp_fault`=1, `rsp_fault_nested`=1, and `rsp_refs` equal to the reads issued, the faulting read included.
- R10: While and after reset, `req_ready`=1, `rsp_valid`=0 and `mem_req`=0. A reset in the middle of a walk abandons it, and the next walk completes normally.
- R11: Entry bits 63:52 and 11:1 have no effect on the result. This includes bit 7 at the third level when the matching 2 MB mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_gva | input | 48 | Guest virtual address |
| req_groot | input | 52 | Guest root pointer (guest physical) |
| req_nroot | input | 52 | Nested root pointer (machine) |
| guest_big | input | 1 | Guest side uses 2 MB leaves |
| host_big | input | 1 | Nested side uses 2 MB leaves |
| mem_req | output | 1 | Memory read issued this cycle |
| mem_addr | output | 52 | Machine address of the entry read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry returned |
| rsp_valid | output | 1 | Walk finished (one cycle) |
| rsp_maddr | output | 52 | Machine address of the data |
| rsp_fault | output | 1 | Walk ended on a non-present entry |
| rsp_fault_nested | output | 1 | Fault was in a nested entry |
| rsp_refs | output | 5 | Reads issued by the walk |

## Verification
A wrong level counter or a wrong leaf decision shows at the ports on the read that follows it, as a wrong `mem_addr`, and by the end of the walk as a wrong `rsp_refs` total (24, 19 or 15). A phase mix-up between the guest and nested sequencers shows as a wrong `rsp_fault_nested` flag when a fault is injected at a chosen read. Such a fault is injected at a read known to be guest or nested: every (m+1)-th read is a guest read. Handshake faults, such as a second read while one is pending, appear within a cycle of the read that caused them.

// File: rtl/walk_pkg.sv
package walk_pkg;
    localparam int VA_W     = 48;
    localparam int PA_W     = 52;
    localparam int ENT_W    = 64;
    localparam int LEVELS   = 4;
    localparam int IDX_W    = 9;
    localparam int PG_SH    = 12;
    localparam int BIG_SH   = PG_SH + IDX_W;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int BIG_LVL  = 1;
    localparam int MAX_REFS = (LEVELS + 1) * (LEVELS + 1) - 1;
    localparam int REF_W    = $clog2(MAX_REFS + 1);

    typedef logic [PA_W-1:0]  pa_t;
    typedef logic [ENT_W-1:0] ent_t;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [REF_W-1:0] ref_t;

    typedef enum logic [1:0] {N_IDLE, N_ISSUE, N_WAIT} nstate_t;
    typedef enum logic [1:0] {G_IDLE, G_NEST, G_ISSUE, G_WAIT} gstate_t;

    // index field of address a for level lvl (lvl 0 = lowest table)
    function automatic logic [IDX_W-1:0] level_index(input pa_t a, input lvl_t lvl);
        return a[PG_SH + IDX_W*int'(lvl) +: IDX_W];
    endfunction

    // entry slot inside a table page; 8-byte entries
    function automatic pa_t entry_addr(input pa_t base, input pa_t a, input lvl_t lvl);
        return {base[PA_W-1:PG_SH], level_index(a, lvl), 3'b000};
    endfunction

    function automatic pa_t next_base(input ent_t e);
        return {e[PA_W-1:PG_SH], {PG_SH{1'b0}}};
    endfunction

    function automatic pa_t leaf_addr(input ent_t e, input pa_t a, input logic big);
        return big ? {e[PA_W-1:BIG_SH], a[BIG_SH-1:0]}
                   : {e[PA_W-1:PG_SH],  a[PG_SH-1:0]};
    endfunction

    function automatic logic is_leaf(input lvl_t lvl, input logic big);
        return (lvl == '0) || (big && (lvl == lvl_t'(BIG_LVL)));
    endfunction
endpackage

// File: rtl/nested_unit.sv
module nested_unit
    import walk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  pa_t  gpa_in,
    input  pa_t  root_in,
    input  logic big_in,
    input  logic rd_valid,
    input  ent_t rd_data,
    output logic rd_req,
    output pa_t  rd_addr,
    output logic done,
    output logic fault,
    output pa_t  maddr
);
    nstate_t st;
    lvl_t    lvl;
    pa_t     gpa_q;
    pa_t     base_q;
    logic    big_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= N_IDLE;
            lvl    <= '0;
            gpa_q  <= '0;
            base_q <= '0;
            big_q  <= 1'b0;
            done   <= 1'b0;
            fault  <= 1'b0;
            maddr  <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                N_IDLE: begin
                    if (start) begin
                        gpa_q  <= gpa_in;
                        base_q <= {root_in[PA_W-1:PG_SH], {PG_SH{1'b0}}};
                        big_q  <= big_in;
                        lvl    <= lvl_t'(LEVELS - 1);
                        st     <= N_ISSUE;
                    end
                end
                N_ISSUE: st <= N_WAIT;
                N_WAIT: begin
                    if (rd_valid) begin
                        if (!rd_data[0]) begin
                            done  <= 1'b1;
                            fault <= 1'b1;
                            maddr <= '0;
                            st    <= N_IDLE;
                        end else if (is_leaf(lvl, big_q)) begin
                            done  <= 1'b1;
                            fault <= 1'b0;
                            maddr <= leaf_addr(rd_data, gpa_q, big_q);
                            st    <= N_IDLE;
                        end else begin
                            base_q <= next_base(rd_data);
                            lvl    <= lvl - 1'b1;
                            st     <= N_ISSUE;
                        end
                    end
                end
                default: st <= N_IDLE;
            endcase
        end
    end

    assign rd_req  = (st == N_ISSUE);
    assign rd_addr = entry_addr(base_q, gpa_q, lvl);
endmodule

// File: rtl/ref_counter.sv
module ref_counter
    import walk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output ref_t count
);
    always_ff @(posedge clk) begin
        if (rst || clear) count <= '0;
        else if (inc)     count <= count + 1'b1;
    end
endmodule

// File: rtl/twod_walker.sv
module twod_walker
    import walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_gva,
    input  logic [PA_W-1:0]   req_groot,
    input  logic [PA_W-1:0]   req_nroot,
    input  logic              guest_big,
    input  logic              host_big,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_maddr,
    output logic              rsp_fault,
    output logic              rsp_fault_nested,
    output logic [REF_W-1:0]  rsp_refs
);
    gstate_t gst;
    lvl_t    glvl;
    pa_t     gva_q, nroot_q, gptr_q, tbl_q;
    logic    gbig_q, nbig_q, final_q, nstart;

    logic    n_req, n_done, n_fault;
    pa_t     n_addr, n_maddr;
    logic    g_req, accept;

    assign req_ready = (gst == G_IDLE);
    assign accept    = req_valid && req_ready;
    assign g_req     = (gst == G_ISSUE);
    assign mem_req   = g_req || n_req;
    assign mem_addr  = g_req ? entry_addr(tbl_q, gva_q, glvl) : n_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            gst              <= G_IDLE;
            glvl             <= '0;
            gva_q            <= '0;
            nroot_q          <= '0;
            gptr_q           <= '0;
            tbl_q            <= '0;
            gbig_q           <= 1'b0;
            nbig_q           <= 1'b0;
            final_q          <= 1'b0;
            nstart           <= 1'b0;
            rsp_valid        <= 1'b0;
            rsp_maddr        <= '0;
            rsp_fault        <= 1'b0;
            rsp_fault_nested <= 1'b0;
        end else begin
            nstart    <= 1'b0;
            rsp_valid <= 1'b0;
            case (gst)
                G_IDLE: begin
                    if (req_valid) begin
                        gva_q   <= {{(PA_W-VA_W){1'b0}}, req_gva};
                        nroot_q <= req_nroot;
                        gptr_q  <= req_groot;
                        gbig_q  <= guest_big;
                        nbig_q  <= host_big;
                        glvl    <= lvl_t'(LEVELS - 1);
                        final_q <= 1'b0;
                        nstart  <= 1'b1;
                        gst     <= G_NEST;
                    end
                end
                G_NEST: begin
                    if (n_done) begin
                        if (n_fault) begin
                            rsp_valid        <= 1'b1;
                            rsp_fault        <= 1'b1;
                            rsp_fault_nested <= 1'b1;
                            rsp_maddr        <= '0;
                            gst              <= G_IDLE;
                        end else if (final_q) begin
                            rsp_valid        <= 1'b1;
                            rsp_fault        <= 1'b0;
                            rsp_fault_nested <= 1'b0;
                            rsp_maddr        <= n_maddr;
                            gst              <= G_IDLE;
                        end else begin
                            tbl_q <= n_maddr;
                            gst   <= G_ISSUE;
                        end
                    end
                end
                G_ISSUE: gst <= G_WAIT;
                G_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!mem_rsp_data[0]) begin
                            rsp_valid        <= 1'b1;
                            rsp_fault        <= 1'b1;
                            rsp_fault_nested <= 1'b0;
                            rsp_maddr        <= '0;
                            gst              <= G_IDLE;
                        end else if (is_leaf(glvl, gbig_q)) begin
                            gptr_q  <= leaf_addr(mem_rsp_data, gva_q, gbig_q);
                            final_q <= 1'b1;
                            nstart  <= 1'b1;
                            gst     <= G_NEST;
                        end else begin
                            gptr_q <= next_base(mem_rsp_data);
                            glvl   <= glvl - 1'b1;
                            nstart <= 1'b1;
                            gst    <= G_NEST;
                        end
                    end
                end
                default: gst <= G_IDLE;
            endcase
        end
    end

    nested_unit u_nest (
        .clk      (clk),
        .rst      (rst),
        .start    (nstart),
        .gpa_in   (gptr_q),
        .root_in  (nroot_q),
        .big_in   (nbig_q),
        .rd_valid (mem_rsp_valid),
        .rd_data  (mem_rsp_data),
        .rd_req   (n_req),
        .rd_addr  (n_addr),
        .done     (n_done),
        .fault    (n_fault),
        .maddr    (n_maddr)
    );

    ref_counter u_refs (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .inc   (mem_req),
        .count (rsp_refs)
    );
endmodule

// File: rtl/walk_chk.sv
module walk_chk
    import walk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             guest_big,
    input logic             host_big,
    input logic             mem_req,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_rsp_valid,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic             rsp_fault_nested,
    input logic [REF_W-1:0] rsp_refs
);
    logic pending;
    ref_t full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            full_q  <= '0;
        end else begin
            if (mem_req)            pending <= 1'b1;
            else if (mem_rsp_valid) pending <= 1'b0;
            if (req_valid && req_ready)
                full_q <= ref_t'(((guest_big ? LEVELS-1 : LEVELS) + 1) *
                                 ((host_big  ? LEVELS-1 : LEVELS) + 1) - 1);
        end
    end

    assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !pending);
    assert_entry_align_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'b000));
    assert_busy_no_ready_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);
    assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // covers R5, R6 and R7 as well: the total follows the sampled modes
    assert_full_walk_refs_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_refs == full_q));
    assert_fault_refs_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_refs <= full_q && rsp_refs != '0));
    assert_nested_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault_nested) |-> rsp_fault);
endmodule

bind twod_walker walk_chk i_walk_chk (.*);

// File: tb/test_twod_walker.sv
module test_twod_walker;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    localparam logic [47:0] T_GVA [NV] = '{
        48'h7F12_3456_789A, 48'h0A5B_6C7D_8E9F, 48'h3333_5555_7777, 48'h1234_0FED_CBA8,
        48'h7F12_3456_789A, 48'h4444_2222_1111, 48'h0ACE_1357_9BDF, 48'h6666_9999_CCCC};
    localparam logic [51:0] T_GR [NV] = '{
        52'h000A_BCDE_F000, 52'h0001_1111_2000, 52'h0002_2222_3000, 52'h0003_3333_4000,
        52'h000A_BCDE_F000, 52'h0004_4444_5000, 52'h0005_5555_6000, 52'h0006_6666_7000};
    localparam logic [51:0] T_NR [NV] = '{
        52'h0001_2345_6000, 52'h0007_7777_8000, 52'h0008_8888_9000, 52'h0009_9999_A000,
        52'h0001_2345_6000, 52'h000B_BBBB_C000, 52'h000C_CCCC_D000, 52'h000D_DDDD_E000};
    localparam bit T_GB [NV] = '{0, 0, 1, 1, 0, 0, 1, 0};
    localparam bit T_NB [NV] = '{0, 1, 1, 0, 0, 0, 1, 0};
    localparam int T_FK [NV] = '{0, 0, 0, 0, 5, 13, 8, 24};
    localparam int T_REFS [NV] = '{24, 19, 15, 19, 5, 13, 8, 24};

    logic clk = 0, rst = 1;
    logic req_valid = 0, guest_big = 0, host_big = 0;
    logic [47:0] req_gva = '0;
    logic [51:0] req_groot = '0, req_nroot = '0;
    logic mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic req_ready, mem_req, rsp_valid, rsp_fault, rsp_fault_nested;
    logic [51:0] mem_addr, rsp_maddr;
    logic [4:0] rsp_refs;

    int total = 0, bad = 0, rd_cnt = 0, fault_at = 0;
    logic [51:0] first_addr = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twod_walker i_twod_walker (.*);

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] ent_of(input logic [51:0] a);
        logic [39:0] h;
        h = (a[42:3] * 40'd2654435761) ^ 40'h3C_5A96_1E77;
        return {12'hA5C, h, 11'h4C1, 1'b1};
    endfunction

    function automatic logic [51:0] xl_nest(input logic [51:0] gpa, input logic [51:0] root, input bit big);
        logic [51:0] base;
        logic [63:0] e;
        base = {root[51:12], 12'h0};
        for (int lv = 3; lv >= 0; lv--) begin
            e = ent_of({base[51:12], gpa[12 + 9*lv +: 9], 3'b000});
            if (lv == 0) return {e[51:12], gpa[11:0]};
            if (big && lv == 1) return {e[51:21], gpa[20:0]};
            base = {e[51:12], 12'h0};
        end
        return '0;
    endfunction

    function automatic logic [51:0] xl_full(input logic [47:0] va, input logic [51:0] gr,
                                            input logic [51:0] nr, input bit gb, input bit nb);
        logic [51:0] ptr, t, v;
        logic [63:0] e;
        ptr = gr;
        v = {4'h0, va};
        for (int lv = 3; lv >= 0; lv--) begin
            t = xl_nest(ptr, nr, nb);
            e = ent_of({t[51:12], v[12 + 9*lv +: 9], 3'b000});
            if (lv == 0) return xl_nest({e[51:12], v[11:0]}, nr, nb);
            if (gb && lv == 1) return xl_nest({e[51:21], v[20:0]}, nr, nb);
            ptr = {e[51:12], 12'h0};
        end
        return '0;
    endfunction

    // memory model: one read at a time, data one cycle after the request is seen
    initial begin
        mem_rsp_valid = 0;
        mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (mem_req && !rst) begin
                logic [51:0] a;
                a = mem_addr;
                rd_cnt++;
                if (rd_cnt == 1) first_addr = a;
                check(a[2:0] == 3'b000, "R2 entry address aligned", {61'h0, a[2:0]}, 64'h0);
                @(negedge clk);
                check(!mem_req, "R2 no second read while pending", {63'h0, mem_req}, 64'h0);
                mem_rsp_data = ent_of(a);
                if (rd_cnt == fault_at) mem_rsp_data[0] = 1'b0;
                mem_rsp_valid = 1;
            end
        end
    end

    task automatic run_walk(input int i, input string tag);
        int n;
        int m;
        logic [51:0] exp_first, exp_ma;
        bit exp_nested;
        rd_cnt = 0;
        fault_at = T_FK[i];
        @(negedge clk);
        req_gva = T_GVA[i]; req_groot = T_GR[i]; req_nroot = T_NR[i];
        guest_big = T_GB[i]; host_big = T_NB[i];
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        check(!req_ready, "R1 ready low while busy", {63'h0, req_ready}, 64'h0);
        n = 0;
        while (!rsp_valid && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(rsp_valid, "R1 response arrives", {63'h0, rsp_valid}, 64'h1);
        exp_first = {T_NR[i][51:12], T_GR[i][47:39], 3'b000};
        check(first_addr == exp_first, "R3 first read is nested root slot", first_addr, exp_first);
        check(rsp_refs == 5'(T_REFS[i]), {tag, " reference count"}, rsp_refs, T_REFS[i]);
        if (T_FK[i] == 0) begin
            exp_ma = xl_full(T_GVA[i], T_GR[i], T_NR[i], T_GB[i], T_NB[i]);
            check(!rsp_fault, {tag, " no fault"}, rsp_fault, 0);
            check(rsp_maddr == exp_ma, {tag, " R11 machine address"}, rsp_maddr, exp_ma);
        end else begin
            m = T_NB[i] ? 3 : 4;
            exp_nested = (T_FK[i] % (m + 1)) != 0;
            check(rsp_fault, {tag, " fault flag"}, rsp_fault, 1);
            check(rsp_fault_nested == exp_nested, {tag, " fault side"}, rsp_fault_nested, exp_nested);
            if (!exp_nested)
                check(rsp_maddr == '0, "R8 address zero on fault", rsp_maddr, 0);
        end
        @(negedge clk);
        check(!rsp_valid, "R1 response is one cycle", {63'h0, rsp_valid}, 64'h0);
        check(req_ready, "R1 ready after response", {63'h0, req_ready}, 64'h1);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!finished) begin
                    total++;
                    bad++;
                    $display("FAIL watchdog expired actual=running expected=done");
                    $display("test done: total=%0d bad=%0d", total, bad);
                    $finish;
                end
            end
        join_none

        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R10 outputs during reset",
              {61'h0, req_ready, rsp_valid, mem_req}, 64'h4);
        rst = 0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req, "R10 outputs after reset",
              {61'h0, req_ready, rsp_valid, mem_req}, 64'h4);

        for (int i = 0; i < NV; i++) begin
            case (i)
                0: run_walk(i, "R4");
                1: run_walk(i, "R5");
                2: run_walk(i, "R6");
                3: run_walk(i, "R7");
                4: run_walk(i, "R8");
                5: run_walk(i, "R9");
                6: run_walk(i, "R8 big pages");
                default: run_walk(i, "R9 last read");
            endcase
        end

        // reset in the middle of a walk
        rd_cnt = 0;
        fault_at = 0;
        @(negedge clk);
        req_gva = T_GVA[0]; req_groot = T_GR[0]; req_nroot = T_NR[0];
        guest_big = 0; host_big = 0;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        repeat (17) @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        check(req_ready && !mem_req && !rsp_valid, "R10 reset abandons walk",
              {61'h0, req_ready, rsp_valid, mem_req}, 64'h4);
        rst = 0;
        run_walk(0, "R10 walk after reset");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule